// File: doc/BRIEF.md
# Memory-to-Memory Copy Sequencer

This block moves a run of bytes from one region of memory to another without the processor touching the data. It keeps two address channels and one transfer counter. Channel 0 holds the source address and channel 1 holds the destination address. The counter belongs to channel 1 and decides when the copy stops.

Each byte takes two bus cycles in a fixed order. The first is a read at the source address, and the byte it returns is captured in an 8-bit holding register. The second is a write of that held byte to the destination address. Because the holding register is one byte wide, the copy always proceeds one byte at a time.

Software starts a copy with a one-cycle request, but only while the memory-to-memory enable bit of the command word is set. A second command bit can freeze the source address, so that a single byte is replicated across the destination region as a fill. The memory side works as a request/ready pair. The active strobe is the request, and a high `mem_wait` withholds ready. While ready is withheld, the sequencer keeps the strobe, the address and the write data unchanged, and it advances only in a cycle where `mem_wait` is low. An external end-of-process input cuts a copy short. After the copy, the holding register still shows the last byte moved.

Top module: `mm_seq`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `mem_wr` and `tc` are all low, and no bus cycle begins until a copy is started.
- R2: A copy started with `xfer_count` = N moves N+1 bytes. Byte i is read from `src_addr`+i and written to `dst_addr`+i.
- R3: For each byte, one read cycle (`mem_rd`) comes first and then one write cycle (`mem_wr`) carrying the byte just read. The two phases strictly alternate, and the two strobes are never high together.
- R4: If `cmd_hold_src` is 1 when the copy is started, every read uses the starting source address, so the whole destination region is filled with that one byte.
- R5: `tc` is high only during the write of the last byte of a copy that runs to its full count. It marks exactly one completed write per such copy.
- R6: While `mem_wait` is high during a read or a write, the strobe, `mem_addr` and `mem_wdata` hold their values. The cycle completes in the first clock cycle in which `mem_wait` is low.
- R7: If `eop_in` is high in any cycle while `busy` is high, the copy ends once the write of the current byte completes. No further read follows, and `tc` stays low unless that byte was the last one anyway.
- R8: A start request is ignored while `cmd_mm_en` is 0 or while a copy is already running. When ignored, it causes no bus cycle and does not change the running copy.
- R9: `tmp_byte` holds the byte captured by the most recent read, and it keeps that value after the copy ends.
- R10: Source and destination addresses advance modulo 2^AW, so a copy that passes the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle software request to begin a copy |
| cmd_mm_en | input | 1 | Command bit: memory-to-memory operation enabled |
| cmd_hold_src | input | 1 | Command bit: keep the source address fixed (fill); sampled at start |
| src_addr | input | AW | Starting source address, loaded into channel 0 at start |
| dst_addr | input | AW | Starting destination address, loaded into channel 1 at start |
| xfer_count | input | CW | Channel 1 count: the number of bytes minus one, loaded at start |
| mem_wait | input | 1 | High withholds ready and stretches the current bus cycle |
| eop_in | input | 1 | External end-of-process: stop after the current write |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | AW | Memory address of the current bus cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data, driven from the holding register |
| tmp_byte | output | 8 | Contents of the byte-wide holding register |
| tc | output | 1 | Terminal count: high during the final write |
| busy | output | 1 | High while a copy is in progress |

## Verification
The hardest case to reach from the ports is an end-of-process that lands in the middle of a copy. It must stop the copy only after the write of the byte already read, and it must not raise terminal count. The bench watches the write strobes it has counted and raises `eop_in` for one cycle exactly while the third read is on the bus. It then checks that three bytes reached the destination and that the fourth destination byte is untouched. A second stimulus drives `mem_wait` from a pseudo-random pattern across a longer copy, so that stalls fall in both read and write phases. Under those stalls the bus must hold its values and the copied bytes must still be correct.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } mm_state_t;
endpackage

// File: rtl/mm_addr_ctr.sv
module mm_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          hold,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step && !hold) begin
      addr <= addr + AW'(1);
    end
  end
endmodule

// File: rtl/mm_word_ctr.sv
module mm_word_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec) begin
      remain <= remain - CW'(1);
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/mm_seq.sv
module mm_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      cmd_mm_en,
  input  logic                      cmd_hold_src,
  input  logic [AW-1:0]             src_addr,
  input  logic [AW-1:0]             dst_addr,
  input  logic [CW-1:0]             xfer_count,
  input  logic                      mem_wait,
  input  logic                      eop_in,
  input  logic [mm_pkg::BYTE_W-1:0] mem_rdata,
  output logic [AW-1:0]             mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [mm_pkg::BYTE_W-1:0] mem_wdata,
  output logic [mm_pkg::BYTE_W-1:0] tmp_byte,
  output logic                      tc,
  output logic                      busy
);
  import mm_pkg::*;

  localparam int NCH = 2;

  mm_state_t state;
  logic      hold_q;
  logic      eop_pend;
  logic      go;
  logic      rd_done;
  logic      wr_done;
  logic      stop;
  logic      cnt_last;

  logic [AW-1:0] ch_addr [NCH];
  logic [AW-1:0] ch_init [NCH];

  assign ch_init[0] = src_addr;
  assign ch_init[1] = dst_addr;

  assign go      = start && cmd_mm_en && (state == ST_IDLE);
  assign rd_done = (state == ST_READ)  && !mem_wait;
  assign wr_done = (state == ST_WRITE) && !mem_wait;
  assign stop    = cnt_last || eop_pend || eop_in;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic ch_hold;
    if (g == 0) begin : g_src
      assign ch_hold = hold_q;
    end else begin : g_dst
      assign ch_hold = 1'b0;
    end
    mm_addr_ctr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go),
      .load_val (ch_init[g]),
      .step     (wr_done),
      .hold     (ch_hold),
      .addr     (ch_addr[g])
    );
  end

  mm_word_ctr #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .load_val (xfer_count),
    .dec      (wr_done),
    .last     (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hold_q   <= 1'b0;
      eop_pend <= 1'b0;
      tmp_byte <= '0;
    end else begin
      if (rd_done) tmp_byte <= mem_rdata;
      unique case (state)
        ST_IDLE: begin
          eop_pend <= 1'b0;
          if (go) begin
            hold_q <= cmd_hold_src;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          if (eop_in) eop_pend <= 1'b1;
          if (!mem_wait) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (eop_in) eop_pend <= 1'b1;
          if (!mem_wait) state <= stop ? ST_IDLE : ST_READ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state == ST_READ);
  assign mem_wr    = (state == ST_WRITE);
  assign mem_addr  = mem_wr ? ch_addr[1] : ch_addr[0];
  assign mem_wdata = tmp_byte;
  assign tc        = mem_wr && cnt_last;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/mm_seq_chk.sv
module mm_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_wait,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          tc,
  input logic          busy
);
  // R3
  p_rw_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_wait) |=> mem_wr);

  // R3
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wait) |=> (mem_rd || !busy));

  // R6
  p_wait_holds_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_wait) |=>
      ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata)));

  // R5
  p_tc_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> mem_wr);

  // R1
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !tc));
endmodule

bind mm_seq mm_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wait  (mem_wait),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .tc        (tc),
  .busy      (busy)
);

// File: tb/sim_mm_seq.sv
module sim_mm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmd_mm_en = 1'b0;
  logic          cmd_hold_src = 1'b0;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [CW-1:0] xfer_count = '0;
  logic          mem_wait = 1'b0;
  logic          eop_in = 1'b0;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, tc, busy;
  logic [7:0]    mem_wdata, tmp_byte;

  logic [7:0] mem [0:255];
  int  checks = 0;
  int  fails = 0;
  int  wr_cnt = 0;
  int  rd_cnt = 0;
  int  tc_cnt = 0;
  bit  wait_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_seq #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_mm_en(cmd_mm_en),
    .cmd_hold_src(cmd_hold_src), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .mem_wait(mem_wait), .eop_in(eop_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .tmp_byte(tmp_byte),
    .tc(tc), .busy(busy)
  );

  assign mem_rdata = mem[mem_addr];

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  always @(posedge clk) begin
    if (mem_wr && !mem_wait) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (tc) tc_cnt <= tc_cnt + 1;
    end
    if (mem_rd && !mem_wait) rd_cnt <= rd_cnt + 1;
  end

  always @(negedge clk) begin
    if (wait_rand) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_wait <= lfsr[0] & lfsr[2];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [7:0] s, input logic [7:0] d, input logic [7:0] n,
                      input logic hold, input logic en);
    src_addr = s; dst_addr = d; xfer_count = n;
    cmd_hold_src = hold; cmd_mm_en = en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_rd && !mem_wr && !tc, "R1 reset outputs", {busy, mem_rd, mem_wr, tc}, 0);
  endtask

  task automatic t_copy();
    int w0 = wr_cnt, r0 = rd_cnt, c0 = tc_cnt;
    kick(8'h10, 8'h40, 8'd3, 1'b0, 1'b1);
    chk(mem_rd && mem_addr == 8'h10, "R3 first cycle is read of source", mem_addr, 8'h10);
    wait_idle();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h40 + i] == pat(8'h10 + i), "R2 copied byte", mem[8'h40 + i], pat(8'h10 + i));
    chk(wr_cnt - w0 == 4 && rd_cnt - r0 == 4, "R3 one read and one write per byte", wr_cnt - w0, 4);
    chk(tc_cnt - c0 == 1, "R5 tc once on final write", tc_cnt - c0, 1);
    chk(tmp_byte == pat(8'h13), "R9 holding register keeps last byte", tmp_byte, pat(8'h13));
  endtask

  task automatic t_fill();
    kick(8'h20, 8'h80, 8'd4, 1'b1, 1'b1);
    wait_idle();
    for (int i = 0; i < 5; i++)
      chk(mem[8'h80 + i] == pat(8'h20), "R4 fill from held source", mem[8'h80 + i], pat(8'h20));
    chk(mem[8'h85] == pat(8'h85), "R4 fill stops at count", mem[8'h85], pat(8'h85));
  endtask

  task automatic t_wait();
    int w0 = wr_cnt, c0 = tc_cnt;
    wait_rand = 1'b1;
    kick(8'h30, 8'h90, 8'd7, 1'b0, 1'b1);
    wait_idle();
    wait_rand = 1'b0;
    @(negedge clk);
    mem_wait = 1'b0;
    for (int i = 0; i < 8; i++)
      chk(mem[8'h90 + i] == pat(8'h30 + i), "R6 byte correct under stalls", mem[8'h90 + i], pat(8'h30 + i));
    chk(wr_cnt - w0 == 8 && tc_cnt - c0 == 1, "R6 completions under stalls", wr_cnt - w0, 8);
  endtask

  task automatic t_eop();
    int w0 = wr_cnt, c0 = tc_cnt;
    kick(8'h50, 8'hA0, 8'd9, 1'b0, 1'b1);
    for (int k = 0; k < 100 && !(mem_rd && wr_cnt - w0 == 2); k++) @(negedge clk);
    eop_in = 1'b1;
    @(negedge clk);
    eop_in = 1'b0;
    wait_idle();
    chk(wr_cnt - w0 == 3, "R7 abort after current write", wr_cnt - w0, 3);
    chk(mem[8'hA2] == pat(8'h52), "R7 current byte written", mem[8'hA2], pat(8'h52));
    chk(mem[8'hA3] == pat(8'hA3), "R7 no byte after abort", mem[8'hA3], pat(8'hA3));
    chk(tc_cnt == c0, "R5 no tc on abort", tc_cnt - c0, 0);
  endtask

  task automatic t_disabled();
    int w0 = wr_cnt, r0 = rd_cnt;
    kick(8'h00, 8'hE0, 8'd2, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) @(negedge clk);
    chk(!busy && wr_cnt == w0 && rd_cnt == r0, "R8 start ignored when disabled", rd_cnt - r0, 0);
    chk(mem[8'hE0] == pat(8'hE0), "R8 memory untouched when disabled", mem[8'hE0], pat(8'hE0));
  endtask

  task automatic t_busy_start();
    kick(8'h70, 8'hB0, 8'd5, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk);
    kick(8'h00, 8'hC0, 8'd1, 1'b1, 1'b1);
    wait_idle();
    for (int i = 0; i < 6; i++)
      chk(mem[8'hB0 + i] == pat(8'h70 + i), "R8 running copy unaffected", mem[8'hB0 + i], pat(8'h70 + i));
    chk(mem[8'hC0] == pat(8'hC0), "R8 second request made no write", mem[8'hC0], pat(8'hC0));
  endtask

  task automatic t_single();
    int w0 = wr_cnt;
    kick(8'h05, 8'hD0, 8'd0, 1'b0, 1'b1);
    wait_idle();
    chk(wr_cnt - w0 == 1 && mem[8'hD0] == pat(8'h05), "R2 count zero moves one byte", wr_cnt - w0, 1);
    chk(mem[8'hD1] == pat(8'hD1), "R2 single copy stops", mem[8'hD1], pat(8'hD1));
  endtask

  task automatic t_wrap();
    kick(8'h60, 8'hFE, 8'd3, 1'b0, 1'b1);
    wait_idle();
    chk(mem[8'hFF] == pat(8'h61), "R10 byte before wrap", mem[8'hFF], pat(8'h61));
    chk(mem[8'h00] == pat(8'h62), "R10 destination wraps to 0", mem[8'h00], pat(8'h62));
    chk(mem[8'h01] == pat(8'h63), "R10 destination after wrap", mem[8'h01], pat(8'h63));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_copy();
    t_fill();
    t_wait();
    t_eop();
    t_disabled();
    t_busy_start();
    t_single();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule